// File: doc/BRIEF.md
# Asynchronous Host Bridge to Shared Message Memory

This block connects a clockless, non-multiplexed host bus to a 2048-word by 16-bit message memory. A protocol processor uses the same memory through a second, synchronous port. The host presents an address and a write strobe, and for a write also the data. It then pulls chip select low for a minimum number of controller clocks. The block brings the strobes into the controller clock domain through two-flop synchronisers and starts one access on the synchronised falling edge of chip select. It then signals completion by pulling ready low.

A read does not drive the bus directly. Its result is latched in a holding register. The host's output-enable strobe puts that register onto the tri-state data bus, and releases the bus to high impedance when output enable is high. Writes never change the holding register. When both ports write the same word in the same clock, the host wins.

Top module: `host_ram_bridge`

## Requirements
- R1: A host write stores the 16-bit data at the addressed word. A later host read of that word returns it. The full 11-bit range, from word 0 to word 2047, is reachable.
- R2: With output enable held low, the read data is on the bus and ready is low no later than 6 controller clocks after chip select falls. Ready is also low within 6 clocks for a write.
- R3: Address, write strobe and write data are sampled within 3 controller clocks of chip select falling. A change on them after that point has no effect on the access.
- R4: A chip select pulse only 2 controller clocks long, with address and data held for 3, completes the access.
- R5: The data bus is driven only while the synchronised output enable is low. It then carries the result of the most recent completed host read, and host writes leave that value unchanged.
- R6: Ready stays low for as long as chip select stays low. It returns high within 3 controller clocks after chip select is released.
- R7: One chip select low period performs exactly one access. No second access starts until chip select has been seen high.
- R8: The internal port writes when enable and write are both high. It reads with one clock of latency. Both ports see the same contents.
- R9: If the host and internal ports write the same word in the same clock, the host data is stored.
- R10: After reset, ready is high, the read holding register is zero and the internal read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 11 | Host word address |
| host_data_io | inout | 16 | Host data bus, tri-state |
| host_cs_ni | input | 1 | Host chip select, active low |
| host_wr_ni | input | 1 | Host write strobe, active low (high = read) |
| host_oe_ni | input | 1 | Host output enable, active low |
| host_rdy_no | output | 1 | Access finished, active low |
| core_en_i | input | 1 | Internal port enable |
| core_we_i | input | 1 | Internal port write |
| core_addr_i | input | 11 | Internal port address |
| core_wdata_i | input | 16 | Internal port write data |
| core_rdata_o | output | 16 | Internal port read data |

## Verification
On every cycle, the assertions check the handshake. Ready falls only a fixed number of clocks after an access starts. It rises only once chip select is seen high, and it leaves once chip select is seen high. They also check that the captured address stays frozen during an access, and that a colliding same-word write keeps the host data. Only the bench scenarios can show the host-visible results. These are the data returned on the bus within the 6-clock window, and immunity to late changes on the address and data. They also cover short chip select pulses, a released bus when output enable is high, the persistence of the last read across writes, and traffic between the two ports.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_LOAD   = 2'd2,
    ST_DONE   = 2'd3
  } hb_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/hb_dpram.sv
module hb_dpram #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  // port A is applied last so it wins on a same-word collision
  always_ff @(posedge clk_i) begin
    if (b_en_i && b_we_i) mem[b_addr_i] <= b_wdata_i;
    if (a_en_i && a_we_i) mem[a_addr_i] <= a_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_en_i) a_rdata_o <= mem[a_addr_i];
      if (b_en_i) b_rdata_o <= mem[b_addr_i];
    end
  end

  p_host_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && a_we_i && b_en_i && b_we_i && (a_addr_i == b_addr_i))
    |=> (mem[$past(a_addr_i)] == $past(a_wdata_i)));
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          wr_s_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic [DW-1:0] rd_hold_o,
  output logic          rdy_no
);
  hb_state_e     state_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          start;

  assign start = (state_q == ST_IDLE) && !cs_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_hold_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          addr_q  <= addr_i;
          we_q    <= !wr_s_i;
          wdata_q <= data_i;
          state_q <= ST_ACCESS;
        end
        ST_ACCESS: state_q <= ST_LOAD;
        ST_LOAD: begin
          if (!we_q) rd_hold_o <= ram_rdata_i;
          state_q <= ST_DONE;
        end
        ST_DONE: if (cs_s_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ram_en_o    = (state_q == ST_ACCESS);
  assign ram_we_o    = we_q;
  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = wdata_q;
  assign rdy_no      = (state_q != ST_DONE);

  p_rdy_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no) |-> $past(start, 3));
  p_rdy_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_no && cs_s_i) |=> rdy_no);
  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_no) |-> $past(cs_s_i));
  p_addr_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE)) |-> $stable(addr_q));
endmodule

// File: rtl/host_ram_bridge.sv
module host_ram_bridge #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] host_addr_i,
  inout  wire  [DW-1:0] host_data_io,
  input  logic          host_cs_ni,
  input  logic          host_wr_ni,
  input  logic          host_oe_ni,
  output logic          host_rdy_no,
  input  logic          core_en_i,
  input  logic          core_we_i,
  input  logic [AW-1:0] core_addr_i,
  input  logic [DW-1:0] core_wdata_i,
  output logic [DW-1:0] core_rdata_o
);
  localparam int unsigned NSTB = 3;

  logic [NSTB-1:0] stb_s;
  logic            cs_s, wr_s, oe_s;
  logic            ram_en, ram_we;
  logic [AW-1:0]   ram_addr;
  logic [DW-1:0]   ram_wdata, ram_rdata, rd_hold;

  hb_sync #(.W(NSTB), .STAGES(SYNC_STAGES), .RST_VAL({NSTB{1'b1}})) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({host_cs_ni, host_wr_ni, host_oe_ni}),
    .q_o    (stb_s)
  );
  assign {cs_s, wr_s, oe_s} = stb_s;

  hb_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s_i      (cs_s),
    .wr_s_i      (wr_s),
    .addr_i      (host_addr_i),
    .data_i      (host_data_io),
    .ram_rdata_i (ram_rdata),
    .ram_en_o    (ram_en),
    .ram_we_o    (ram_we),
    .ram_addr_o  (ram_addr),
    .ram_wdata_o (ram_wdata),
    .rd_hold_o   (rd_hold),
    .rdy_no      (host_rdy_no)
  );

  hb_dpram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_en_i    (ram_en),
    .a_we_i    (ram_we),
    .a_addr_i  (ram_addr),
    .a_wdata_i (ram_wdata),
    .a_rdata_o (ram_rdata),
    .b_en_i    (core_en_i),
    .b_we_i    (core_we_i),
    .b_addr_i  (core_addr_i),
    .b_wdata_i (core_wdata_i),
    .b_rdata_o (core_rdata_o)
  );

  assign host_data_io = !oe_s ? rd_hold : {DW{1'bz}};
endmodule

// File: tb/tb_host_ram_bridge.sv
`timescale 1ns/1ps
module tb_host_ram_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        cs_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic        drv_en = 1'b0;
  logic [15:0] drv = '0;
  wire  [15:0] bus;
  logic        rdy_n;
  logic        c_en = 1'b0, c_we = 1'b0;
  logic [10:0] c_addr = '0;
  logic [15:0] c_wdata = '0;
  logic [15:0] c_rdata;
  int          checks = 0, errors = 0;

  assign bus = drv_en ? drv : 16'hzzzz;

  always #4 clk = ~clk;

  host_ram_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_data_io(bus),
    .host_cs_ni(cs_n), .host_wr_ni(wr_n), .host_oe_ni(oe_n), .host_rdy_no(rdy_n),
    .core_en_i(c_en), .core_we_i(c_we), .core_addr_i(c_addr),
    .core_wdata_i(c_wdata), .core_rdata_o(c_rdata)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle_end();
    cs_n = 1'b1;
    step(3);
    chk("R6 ready high after release", {15'd0, rdy_n}, 16'd1);
    wr_n = 1'b1; drv_en = 1'b0;
    step(1);
  endtask

  task automatic host_write(logic [10:0] a, logic [15:0] d);
    oe_n = 1'b1; step(3);
    addr = a; wr_n = 1'b0; drv = d; drv_en = 1'b1;
    step(1);
    cs_n = 1'b0;
    step(6);
    chk("R2 write ready", {15'd0, rdy_n}, 16'd0);
    cycle_end();
  endtask

  task automatic host_read(logic [10:0] a, logic [15:0] exp, string tag);
    oe_n = 1'b0; drv_en = 1'b0;
    addr = a; wr_n = 1'b1;
    step(1);
    cs_n = 1'b0;
    step(6);
    chk({tag, " read data"}, bus, exp);
    chk("R2 read ready", {15'd0, rdy_n}, 16'd0);
    cycle_end();
  endtask

  task automatic t_reset();
    chk("R10 ready after reset", {15'd0, rdy_n}, 16'd1);
    chk("R10 core rdata after reset", c_rdata, 16'h0000);
    oe_n = 1'b0; step(3);
    chk("R10 hold reg after reset", bus, 16'h0000);
    oe_n = 1'b1; step(3);
  endtask

  task automatic t_basic();
    host_write(11'h123, 16'hA5A5);
    host_write(11'h000, 16'hFFFF);
    host_write(11'h7FF, 16'h8001);
    host_read(11'h123, 16'hA5A5, "R1 R2 mid");
    host_read(11'h7FF, 16'h8001, "R1 top word");
    host_read(11'h000, 16'hFFFF, "R1 word0");
    host_write(11'h000, 16'h0000);
    host_read(11'h000, 16'h0000, "R1 zero");
  endtask

  task automatic t_capture();
    host_write(11'h011, 16'h0BAD);
    oe_n = 1'b1; step(3);
    addr = 11'h010; wr_n = 1'b0; drv = 16'h1111; drv_en = 1'b1;
    step(1);
    cs_n = 1'b0;
    step(3);
    addr = 11'h011; drv = 16'h2222;  // late change must not matter
    step(5);
    cycle_end();
    host_read(11'h010, 16'h1111, "R3 captured word");
    host_read(11'h011, 16'h0BAD, "R3 neighbour untouched");
  endtask

  task automatic t_short_cs();
    oe_n = 1'b1; step(3);
    addr = 11'h2AA; wr_n = 1'b0; drv = 16'h5A3C; drv_en = 1'b1;
    step(1);
    cs_n = 1'b0;
    step(2);
    cs_n = 1'b1;
    step(1);
    wr_n = 1'b1; drv_en = 1'b0; addr = 11'h000;
    step(6);
    chk("R4 ready high at end of short cycle", {15'd0, rdy_n}, 16'd1);
    host_read(11'h2AA, 16'h5A3C, "R4 short pulse");
  endtask

  task automatic t_oe();
    host_write(11'h040, 16'hC0DE);
    host_read(11'h040, 16'hC0DE, "R5 setup");
    oe_n = 1'b1; step(3);
    drv = 16'h0000; drv_en = 1'b1; step(1);
    chk("R5 bus released when oe high", bus, 16'h0000);
    drv_en = 1'b0;
    host_write(11'h041, 16'h1234);
    oe_n = 1'b0; step(3);
    chk("R5 last read kept across write", bus, 16'hC0DE);
    oe_n = 1'b1; step(3);
  endtask

  task automatic t_long_cs();
    oe_n = 1'b1; step(3);
    addr = 11'h300; wr_n = 1'b0; drv = 16'h600D; drv_en = 1'b1;
    step(1);
    cs_n = 1'b0;
    step(3);
    drv = 16'hBEEF;
    step(20);
    chk("R6 ready held while cs low", {15'd0, rdy_n}, 16'd0);
    cycle_end();
    host_read(11'h300, 16'h600D, "R7 single access");
  endtask

  task automatic t_core();
    c_en = 1'b1; c_we = 1'b1; c_addr = 11'h055; c_wdata = 16'h7E7E;
    step(1);
    c_en = 1'b0; c_we = 1'b0;
    host_read(11'h055, 16'h7E7E, "R8 core write seen by host");
    host_write(11'h066, 16'h3C3C);
    c_en = 1'b1; c_addr = 11'h066;
    step(1);
    c_en = 1'b0;
    chk("R8 core read of host data", c_rdata, 16'h3C3C);
  endtask

  task automatic t_prio();
    oe_n = 1'b1; step(3);
    addr = 11'h077; wr_n = 1'b0; drv = 16'hAAAA; drv_en = 1'b1;
    step(1);
    cs_n = 1'b0;
    step(3);
    c_en = 1'b1; c_we = 1'b1; c_addr = 11'h077; c_wdata = 16'h5555;
    step(1);
    c_en = 1'b0; c_we = 1'b0;
    step(2);
    cycle_end();
    host_read(11'h077, 16'hAAAA, "R9 host wins");
    c_en = 1'b1; c_addr = 11'h077;
    step(1);
    c_en = 1'b0;
    chk("R9 core sees host data", c_rdata, 16'hAAAA);
  endtask

  initial begin
    fork
      begin
        step(2);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_basic();
        t_capture();
        t_short_cs();
        t_oe();
        t_long_cs();
        t_core();
        t_prio();
      end
      begin
        step(20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule